// File: doc/BRIEF.md
# GPIO Port with Pin-Change and Edge Interrupts

An eight-pin general-purpose I/O port sits between a small register bus and the pads. Every pin has a direction bit and an output latch bit. A peripheral that needs a pin can take over its direction through a per-pin override. One active-low control bit turns on weak pull-ups for the whole port. A pin driven as an output never gets a pull-up. All pad inputs pass through a two-flop synchronizer before any logic sees them.

The upper four pins feed a change detector. Each upper pin that is an input is compared against a snapshot of the port. The snapshot is taken each time software reads or writes the port register. A difference sets a change flag.

The change flag is tracked by a three-state machine:
- **CHG_CLEAR**: no flag.
- **CHG_HELD**: flag set and a mismatch is present. Clear requests are ignored in this state.
- **CHG_LATCHED**: flag set and the mismatch has gone.

The transitions are:
- **arm**: CLEAR to HELD on a mismatch.
- **settle**: HELD to LATCHED when the mismatch ends.
- **retrigger**: LATCHED to HELD on a new mismatch.
- **acknowledge**: LATCHED to CLEAR on a software clear.

Pin 0 is also an external interrupt input. Its rising or falling edge, as selected, sets a sticky edge flag. The interrupt output ORs each flag with its own enable. The wake output asserts the enabled change interrupt while the core reports that it is asleep.

Top module: `gpio_cport`

Register map (`bus_addr`):

| Address | Register | Read | Write |
|---|---|---|---|
| 0 | Port | Synchronized pin levels | Output latch |
| 1 | Direction | Stored direction (1 = input) | Stored direction |
| 2 | Control | Stored control bits | Control bits |
| 3 | Flags | Both flags | Writing 0 to a flag bit requests its clear; writing 1 does nothing |

Control register bits:
- bit 7: pull-up disable, active low.
- bit 6: edge select (1 = rising edge).
- bit 1: edge-interrupt enable.
- bit 0: change-interrupt enable.

Flags register bits:
- bit 0: change flag.
- bit 1: edge flag.

A read or a write of address 0 reloads the change snapshot.

## Requirements
- R1: After reset, Direction reads 0xFF, Control reads 0xC0, Flags reads 0x00, and `pad_out`, `pad_oe` and `pu_en` are all 0.
- R2: When no override is active, `pad_oe[i]` is the inverse of Direction bit i, and `pad_out` equals the output latch last written to address 0.
- R3: `pu_en[i]` is 1 only when Control bit 7 is 0 and pin i is effectively an input.
- R4: When `ovr_en[i]` is 1, the effective direction of pin i is `ovr_dir[i]` (1 = input), whatever the stored Direction bit holds. The override does not change the stored Direction value.
- R5: A read of address 0 returns the pad levels delayed by two clock edges. Reads of addresses 1 and 2 return the stored values.
- R6: An upper pin (7 to 4) that is an input and differs from the snapshot sets Flags bit 0 by the third clock edge after the pad changes. Changes on pins 3 to 0 never set Flags bit 0, and neither do changes on upper pins configured as outputs.
- R7: While the mismatch persists, writing 0 to Flags bit 0 leaves it at 1. After a port access reloads the snapshot, writing 0 clears it.
- R8: With Control bit 6 = 1, a rising edge on pin 0 sets Flags bit 1; with bit 6 = 0, a falling edge sets it. The other edge has no effect. Writing 0 to Flags bit 1 clears it.
- R9: `irq` equals (Flags bit 0 AND Control bit 0) OR (Flags bit 1 AND Control bit 1). `wake` equals `sleep` AND Flags bit 0 AND Control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of address 0 reloads the snapshot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Output latch value for the pads |
| pad_oe | output | 8 | Per-pin output driver enable |
| pu_en | output | 8 | Per-pin weak pull-up enable |
| ovr_en | input | 8 | Per-pin peripheral direction override enable |
| ovr_dir | input | 8 | Override direction (1 = input) |
| sleep | input | 1 | Core is asleep |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Wake request from the change detector |

## Verification
Most internal errors show up directly at the pins:
- A corrupt direction or override path shows on `pad_oe` and `pu_en` in the same cycle as the register write.
- A synchronizer of the wrong depth shifts the port read-back by one edge, which the bench observes.

The change machine is observed through Flags and `irq`:
- Settling back to CLEAR while the mismatch remains would be seen as soon as a clear is written.
- Skipping the snapshot reload would keep Flags bit 0 stuck at 1 after the acknowledge.

An inverted edge select appears within three edges of a pin-0 transition.

// File: rtl/gpio_cport_pkg.sv
package gpio_cport_pkg;
    typedef enum logic [1:0] {
        REG_PORT = 2'd0,
        REG_DIR  = 2'd1,
        REG_CTRL = 2'd2,
        REG_FLAG = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CHG_CLEAR   = 2'd0,
        CHG_HELD    = 2'd1,
        CHG_LATCHED = 2'd2
    } chg_state_e;

    localparam int CTRL_PU_N   = 7;
    localparam int CTRL_EDGE   = 6;
    localparam int CTRL_EXT_IE = 1;
    localparam int CTRL_CHG_IE = 0;
    localparam int FLAG_CHG    = 0;
    localparam int FLAG_EXT    = 1;
endpackage

// File: rtl/gpio_cport_sync.sv
module gpio_cport_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_cport_regs.sv
module gpio_cport_regs
    import gpio_cport_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int CHG_LO = 4,
    localparam int CHG_W = WIDTH - CHG_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] in_sync,
    input  logic             chg_flag,
    output logic [WIDTH-1:0] latch,
    output logic [WIDTH-1:0] dir,
    output logic             pu_n,
    output logic             edge_rise,
    output logic             ext_ie,
    output logic             chg_ie,
    output logic             ext_flag,
    output logic [CHG_W-1:0] snap_hi,
    output logic             port_acc,
    output logic             clr_chg,
    output logic             in0_prev
);
    reg_sel_e sel;
    logic     flag_wr;
    logic     ext_hit;

    assign sel      = reg_sel_e'(bus_addr);
    assign port_acc = (bus_wr || bus_rd) && (sel == REG_PORT);
    assign flag_wr  = bus_wr && (sel == REG_FLAG);
    assign clr_chg  = flag_wr && !bus_wdata[FLAG_CHG];
    assign ext_hit  = edge_rise ? (in_sync[0] && !in0_prev)
                                : (!in_sync[0] && in0_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch     <= '0;
            dir       <= '1;
            pu_n      <= 1'b1;
            edge_rise <= 1'b1;
            ext_ie    <= 1'b0;
            chg_ie    <= 1'b0;
        end else if (bus_wr) begin
            unique case (sel)
                REG_PORT: latch <= bus_wdata;
                REG_DIR:  dir   <= bus_wdata;
                REG_CTRL: begin
                    pu_n      <= bus_wdata[CTRL_PU_N];
                    edge_rise <= bus_wdata[CTRL_EDGE];
                    ext_ie    <= bus_wdata[CTRL_EXT_IE];
                    chg_ie    <= bus_wdata[CTRL_CHG_IE];
                end
                REG_FLAG: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_hi  <= '0;
            in0_prev <= 1'b0;
            ext_flag <= 1'b0;
        end else begin
            in0_prev <= in_sync[0];
            if (port_acc) snap_hi <= in_sync[WIDTH-1:CHG_LO];
            if (ext_hit)
                ext_flag <= 1'b1;
            else if (flag_wr && !bus_wdata[FLAG_EXT])
                ext_flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_PORT: bus_rdata = in_sync;
            REG_DIR:  bus_rdata = dir;
            REG_CTRL: begin
                bus_rdata[CTRL_PU_N]   = pu_n;
                bus_rdata[CTRL_EDGE]   = edge_rise;
                bus_rdata[CTRL_EXT_IE] = ext_ie;
                bus_rdata[CTRL_CHG_IE] = chg_ie;
            end
            REG_FLAG: begin
                bus_rdata[FLAG_CHG] = chg_flag;
                bus_rdata[FLAG_EXT] = ext_flag;
            end
        endcase
    end
endmodule

// File: rtl/gpio_cport_chg.sv
module gpio_cport_chg
    import gpio_cport_pkg::*;
#(
    parameter int CHG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CHG_W-1:0] live_hi,
    input  logic [CHG_W-1:0] snap_hi,
    input  logic [CHG_W-1:0] in_mask,
    input  logic             port_acc,
    input  logic             clr_req,
    output logic             chg_flag,
    output logic             chg_hit
);
    chg_state_e state, state_n;

    assign chg_hit = (|((live_hi ^ snap_hi) & in_mask)) && !port_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CHG_CLEAR;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            CHG_CLEAR:   if (chg_hit) state_n = CHG_HELD;
            CHG_HELD:    if (!chg_hit) state_n = CHG_LATCHED;
            CHG_LATCHED: begin
                if (chg_hit)      state_n = CHG_HELD;
                else if (clr_req) state_n = CHG_CLEAR;
            end
            default:     state_n = CHG_CLEAR;
        endcase
    end

    always_comb begin
        chg_flag = (state == CHG_HELD) || (state == CHG_LATCHED);
    end
endmodule

// File: rtl/gpio_cport.sv
module gpio_cport
    import gpio_cport_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int CHG_LO      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CHG_W      = WIDTH - CHG_LO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pu_en,
    input  logic [WIDTH-1:0] ovr_en,
    input  logic [WIDTH-1:0] ovr_dir,
    input  logic             sleep,
    output logic             irq,
    output logic             wake
);
    logic [WIDTH-1:0] in_sync;
    logic [WIDTH-1:0] latch, dir, eff_dir;
    logic [CHG_W-1:0] snap_hi;
    logic pu_n, edge_rise, ext_ie, chg_ie, ext_flag, chg_flag, chg_hit;
    logic port_acc, clr_chg, in0_prev;

    gpio_cport_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
    );

    gpio_cport_regs #(.WIDTH(WIDTH), .CHG_LO(CHG_LO)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_sync(in_sync), .chg_flag(chg_flag),
        .latch(latch), .dir(dir), .pu_n(pu_n), .edge_rise(edge_rise),
        .ext_ie(ext_ie), .chg_ie(chg_ie), .ext_flag(ext_flag),
        .snap_hi(snap_hi), .port_acc(port_acc), .clr_chg(clr_chg),
        .in0_prev(in0_prev)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign eff_dir[i] = ovr_en[i] ? ovr_dir[i] : dir[i];
        assign pad_oe[i]  = !eff_dir[i];
        assign pu_en[i]   = eff_dir[i] && !pu_n;
    end

    assign pad_out = latch;

    gpio_cport_chg #(.CHG_W(CHG_W)) u_chg (
        .clk(clk), .rst_n(rst_n),
        .live_hi(in_sync[WIDTH-1:CHG_LO]), .snap_hi(snap_hi),
        .in_mask(eff_dir[WIDTH-1:CHG_LO]),
        .port_acc(port_acc), .clr_req(clr_chg),
        .chg_flag(chg_flag), .chg_hit(chg_hit)
    );

    assign irq  = (chg_flag && chg_ie) || (ext_flag && ext_ie);
    assign wake = sleep && chg_flag && chg_ie;
endmodule

// File: rtl/gpio_cport_chk.sv
module gpio_cport_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pu_en,
    input logic [WIDTH-1:0] ovr_en,
    input logic [WIDTH-1:0] ovr_dir,
    input logic             irq,
    input logic             wake,
    input logic             chg_flag,
    input logic             chg_hit,
    input logic             port_acc,
    input logic             ext_flag,
    input logic             edge_rise,
    input logic             in_sync0,
    input logic             in0_prev
);
    // R3
    pullup_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_en & pad_oe) == '0);

    // R4
    ovr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en & ~ovr_dir & ~pad_oe) == '0);

    // R4
    ovr_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en & ovr_dir & pad_oe) == '0);

    // R6
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_flag) |-> $past(chg_hit));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && chg_hit && !port_acc) |=> chg_flag);

    // R8
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rise && in_sync0 && !in0_prev) |=> ext_flag);

    // R9
    wake_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> irq);
endmodule

bind gpio_cport gpio_cport_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .pad_oe(pad_oe), .pu_en(pu_en),
    .ovr_en(ovr_en), .ovr_dir(ovr_dir), .irq(irq), .wake(wake),
    .chg_flag(chg_flag), .chg_hit(chg_hit), .port_acc(port_acc),
    .ext_flag(ext_flag), .edge_rise(edge_rise),
    .in_sync0(in_sync[0]), .in0_prev(in0_prev)
);

// File: tb/gpio_cport_test.sv
`timescale 1ns/1ps
module gpio_cport_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pu_en;
    logic [7:0] ovr_en = 8'h00, ovr_dir = 8'h00;
    logic       sleep = 1'b0;
    logic       irq, wake;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    gpio_cport uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pu_en(pu_en),
        .ovr_en(ovr_en), .ovr_dir(ovr_dir), .sleep(sleep), .irq(irq), .wake(wake)
    );

    function automatic logic [7:0] eff_dir_f(logic [7:0] d, logic [7:0] oe, logic [7:0] od);
        return (oe & od) | (~oe & d);
    endfunction

    function automatic logic [7:0] pu_f(logic [7:0] ed, logic pun);
        return pun ? 8'h00 : ed;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #0.5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic resync_clear();
        logic [7:0] v;
        rd(2'd0, v);
        wr(2'd3, 8'h00);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v, d, l, c;
        void'($urandom(32'h1234_5A5A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, v); chk("R1 dir", v, 8'hFF);
        rd(2'd2, v); chk("R1 ctrl", v, 8'hC0);
        rd(2'd3, v); chk("R1 flags", v, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pu_en", pu_en, 8'h00);

        // R2 R3 R4 constrained random
        for (int n = 0; n < 150; n++) begin
            d = 8'($urandom); l = 8'($urandom);
            c = (($urandom % 2) != 0) ? 8'h40 : 8'hC0;
            ovr_en  = ((n % 3) == 0) ? 8'h00 : 8'($urandom);
            ovr_dir = 8'($urandom);
            wr(2'd1, d); wr(2'd0, l); wr(2'd2, c);
            #0.5;
            chk("R2 pad_out", pad_out, l);
            chk("R2 R4 pad_oe", pad_oe, ~eff_dir_f(d, ovr_en, ovr_dir));
            chk("R3 pu_en", pu_en, pu_f(eff_dir_f(d, ovr_en, ovr_dir), c[7]));
            rd(2'd1, v); chk("R4 R5 dir readback", v, d);
            rd(2'd2, v); chk("R5 ctrl readback", v, c);
        end
        ovr_en = 8'h00;
        wr(2'd1, 8'hFF); wr(2'd2, 8'hC0);

        // R5 random pad read-back
        for (int n = 0; n < 20; n++) begin
            l = 8'($urandom);
            @(negedge clk); pad_in = l;
            repeat (3) @(negedge clk);
            rd(2'd0, v); chk("R5 port read", v, l);
        end
        // R5 sync latency: old value after one edge, new after two
        @(negedge clk); l = pad_in; pad_in = ~l; bus_addr = 2'd0;
        @(negedge clk); chk("R5 one edge", bus_rdata, l);
        @(negedge clk); chk("R5 two edges", bus_rdata, ~l);
        @(negedge clk); pad_in = 8'h00;
        settle();
        resync_clear();
        rd(2'd3, v); chk("R7 R8 flags clean", v, 8'h00);

        // enable both interrupts, rising edge
        wr(2'd2, 8'hC3);
        @(negedge clk); pad_in = 8'h04; settle();
        rd(2'd3, v); chk("R6 low pin ignored", v, 8'h00);
        @(negedge clk); pad_in = 8'h24; settle();
        rd(2'd3, v); chk("R6 upper pin sets", v, 8'h01);
        chk("R9 irq change", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'h00);
        rd(2'd3, v); chk("R7 clear ignored", v, 8'h01);
        rd(2'd0, v); chk("R5 port value", v, 8'h24);
        wr(2'd3, 8'h00);
        rd(2'd3, v); chk("R7 clear after access", v, 8'h00);
        chk("R9 irq low", {7'd0, irq}, 8'h00);

        // R6 output pin masked
        wr(2'd1, 8'hBF);
        @(negedge clk); pad_in = 8'h64; settle();
        rd(2'd3, v); chk("R6 output masked", v, 8'h00);
        @(negedge clk); pad_in = 8'h24; settle();
        wr(2'd1, 8'hFF);

        // R9 wake
        sleep = 1'b1;
        @(negedge clk); pad_in = 8'hA4; settle();
        chk("R9 wake", {7'd0, wake}, 8'h01);
        sleep = 1'b0; #0.5;
        chk("R9 wake off", {7'd0, wake}, 8'h00);
        wr(2'd2, 8'hC2); #0.5;
        chk("R9 irq masked", {7'd0, irq}, 8'h00);
        resync_clear();

        // R8 edges
        @(negedge clk); pad_in = 8'hA5; settle();
        rd(2'd3, v); chk("R8 rising sets", v, 8'h02);
        chk("R9 irq edge", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'hFD);
        rd(2'd3, v); chk("R8 clear", v, 8'h00);
        @(negedge clk); pad_in = 8'hA4; settle();
        rd(2'd3, v); chk("R8 falling ignored", v, 8'h00);
        wr(2'd2, 8'h82);
        @(negedge clk); pad_in = 8'hA5; settle();
        rd(2'd3, v); chk("R8 rising ignored", v, 8'h00);
        @(negedge clk); pad_in = 8'hA4; settle();
        rd(2'd3, v); chk("R8 falling sets", v, 8'h02);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule